// File: doc/BRIEF.md
# Flash Command Interface Controller

This block sits between a CPU-side bus and an on-chip flash array while the array is being reprogrammed. The CPU writes command codes and reads back data with 16-bit accesses at even byte addresses. The controller decodes each command code and keeps a read mode. Each read then returns either a word of the array or the 8-bit status register.

A read-array command selects a persistent mode in which every read returns array contents. A read-status command arms a one-shot: only the next read returns status, and the block then falls back to array reads. A clear-status command wipes the three sticky error bits. External error pulses set those bits.

A flash reset input forces array mode, with the same effect as the read-array command. An exit guard flags any attempt to leave reprogramming when neither the read-array command nor a flash reset has been issued since the last status or clear command.

Top module: `fcmd_ctrl`

## Requirements
- R1: After synchronous reset, `bus_rdata` is 0x0000, `exit_bad` is 0, the block is in array mode, and the status register reads 0x80.
- R2: A write of code 0xFF (low byte of `bus_wdata`) at an even address selects array mode. A read at even byte address A then returns word W(A>>1), where W(i) = ((i * 0x9E37) XOR 0x1D2C) mod 2^16.
- R3: Array mode stays in force across any number of consecutive reads until another recognised command is written.
- R4: After code 0x70, the next even-address read returns {8'h00, status}, and the read after that returns array data again.
- R5: Bits 15..8 of the write data are ignored when a command is decoded (for example, 0xAB70 acts as 0x70).
- R6: Code 0x50 clears status bits 5..3, leaves bit 7 and the read mode unchanged, and an error pulse in the same cycle still sets its bit.
- R7: A pulse on `err_set[k]` sets status bit 3+k, which stays set until 0x50 or `rst`. Bit 7 always reads 1, and bits 6 and 2..0 read 0.
- R8: Asserting `flash_reset` forces array mode and counts as a safe exit point like 0xFF. It does not clear the status bits.
- R9: Writes and reads at odd addresses are ignored: the mode is unchanged, `bus_rdata` keeps its value, and a pending status one-shot is not consumed.
- R10: Writes of any code other than 0xFF, 0x70 and 0x50 leave the mode and the exit-guard state unchanged.
- R11: `exit_bad` is 1 in the cycle after an `exit_req` pulse when a 0x70 or 0x50 was written after the latest 0xFF, flash reset or `rst`. Otherwise it is 0.
- R12: `bus_rdata` changes one clock after a read strobe is sampled and holds its value when no read occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access, never together with `bus_wr` |
| bus_addr | input | ADDR_W | Byte address, only even values are accepted |
| bus_wdata | input | 16 | Write data; the low byte carries the command code |
| bus_rdata | output | 16 | Registered read data |
| flash_reset | input | 1 | Flash reset control, forces array mode |
| err_set | input | 3 | Error pulses setting status bits 3..5 |
| exit_req | input | 1 | Pulse marking an attempt to leave reprogramming |
| exit_bad | output | 1 | Flags an exit not preceded by 0xFF or a flash reset |

## Verification
Read data is due exactly one clock after the read strobe is sampled. The monitor therefore compares `bus_rdata` at the falling edge that follows the capturing rising edge, and pops one expected word from the queue per sampled read. Odd-address reads push the previously read value, which checks the hold behaviour. Mode and status changes from a write take effect at the same edge, so the very next read observes them. `exit_bad` is sampled at the falling edge after the `exit_req` edge, and the expected value comes from a bench model of the safe-exit state.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

    localparam logic [7:0] CODE_ARRAY  = 8'hFF;
    localparam logic [7:0] CODE_STATUS = 8'h70;
    localparam logic [7:0] CODE_CLEAR  = 8'h50;
    localparam int         N_ERR       = 3;
    localparam int         DATA_W      = 16;

    typedef enum logic {
        RMODE_ARRAY  = 1'b0,
        RMODE_STATUS = 1'b1
    } rmode_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_ARRAY,
        OP_STATUS,
        OP_CLEAR
    } cmd_op_e;

    typedef struct packed {
        logic             ready;
        logic             rsv_hi;
        logic [N_ERR-1:0] err;
        logic [2:0]       rsv_lo;
    } status_t;

    function automatic cmd_op_e decode_code(input logic [7:0] code);
        case (code)
            CODE_ARRAY:  return OP_ARRAY;
            CODE_STATUS: return OP_STATUS;
            CODE_CLEAR:  return OP_CLEAR;
            default:     return OP_NONE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] array_word(input logic [31:0] idx);
        logic [31:0] prod;
        prod = idx * 32'h0000_9E37;
        return prod[DATA_W-1:0] ^ 16'h1D2C;
    endfunction

endpackage

// File: rtl/fcmd_decode.sv
module fcmd_decode
    import fcmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_go,
    input  logic       rd_go,
    input  logic       wr_odd,
    input  logic [7:0] code,
    input  logic       flash_reset,
    output rmode_e     mode,
    output logic       safe,
    output logic       clr_pulse
);
    cmd_op_e op;
    rmode_e  mode_q, mode_d;
    logic    safe_q, safe_d;

    always_comb op = wr_go ? decode_code(code) : OP_NONE;

    always_comb begin
        mode_d = mode_q;
        safe_d = safe_q;
        if (flash_reset) begin
            mode_d = RMODE_ARRAY;
            safe_d = 1'b1;
        end else begin
            case (op)
                OP_ARRAY:  begin mode_d = RMODE_ARRAY;  safe_d = 1'b1; end
                OP_STATUS: begin mode_d = RMODE_STATUS; safe_d = 1'b0; end
                OP_CLEAR:  safe_d = 1'b0;
                default: begin
                    if (rd_go && mode_q == RMODE_STATUS)
                        mode_d = RMODE_ARRAY;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= RMODE_ARRAY;
            safe_q <= 1'b1;
        end else begin
            mode_q <= mode_d;
            safe_q <= safe_d;
        end
    end

    assign mode      = mode_q;
    assign safe      = safe_q;
    assign clr_pulse = (op == OP_CLEAR) && !flash_reset;

    // R2
    array_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_go && code == CODE_ARRAY) |=> (mode == RMODE_ARRAY && safe));

    // R4
    status_oneshot_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_go && mode == RMODE_STATUS && !flash_reset) |=> (mode == RMODE_ARRAY));

    // R9
    odd_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_odd && !flash_reset) |=> $stable(mode));

    // R8
    flash_reset_chk: assert property (@(posedge clk) disable iff (rst)
        flash_reset |=> (mode == RMODE_ARRAY && safe));

endmodule

// File: rtl/fcmd_status.sv
module fcmd_status
    import fcmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [N_ERR-1:0] err_set,
    output logic [7:0]       status
);
    logic [N_ERR-1:0] err_q;
    status_t          st;

    always_ff @(posedge clk) begin
        if (rst)      err_q <= '0;
        else if (clr) err_q <= err_set;
        else          err_q <= err_q | err_set;
    end

    always_comb begin
        st.ready  = 1'b1;
        st.rsv_hi = 1'b0;
        st.err    = err_q;
        st.rsv_lo = 3'b000;
    end

    assign status = st;

    // R7
    err_set_chk: assert property (@(posedge clk) disable iff (rst)
        (err_set != '0) |=> ((status[5:3] & $past(err_set)) == $past(err_set)));

    // R6
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && err_set == '0) |=> (status[5:3] == 3'b000));

    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((status[5:3] & $past(status[5:3])) == $past(status[5:3])));

endmodule

// File: rtl/fcmd_array.sv
module fcmd_array
    import fcmd_pkg::*;
#(
    parameter int WORD_AW = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_en,
    input  logic [WORD_AW-1:0] word_addr,
    output logic [DATA_W-1:0]  rdata
);
    localparam int DEPTH = 1 << WORD_AW;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        assign mem[i] = array_word(32'(i));
    end

    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (rd_en) q <= mem[word_addr];
    end

    assign rdata = q;
endmodule

// File: rtl/fcmd_ctrl.sv
module fcmd_ctrl
    import fcmd_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              flash_reset,
    input  logic [2:0]        err_set,
    input  logic              exit_req,
    output logic              exit_bad
);
    localparam int WORD_AW = ADDR_W - 1;

    logic       even, wr_go, rd_go, wr_odd;
    rmode_e     mode;
    logic       safe, clr_pulse;
    logic [7:0] status;
    logic [15:0] arr_q, stat_q;
    rmode_e     src_q;
    logic       exit_bad_q;
    logic       unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[15:8];
    assign even   = !bus_addr[0];
    assign wr_go  = bus_wr && even;
    assign rd_go  = bus_rd && even;
    assign wr_odd = bus_wr && !even;

    fcmd_decode u_decode (
        .clk(clk), .rst(rst), .wr_go(wr_go), .rd_go(rd_go), .wr_odd(wr_odd),
        .code(bus_wdata[7:0]), .flash_reset(flash_reset),
        .mode(mode), .safe(safe), .clr_pulse(clr_pulse)
    );

    fcmd_status u_status (
        .clk(clk), .rst(rst), .clr(clr_pulse), .err_set(err_set), .status(status)
    );

    fcmd_array #(.WORD_AW(WORD_AW)) u_array (
        .clk(clk), .rst(rst),
        .rd_en(rd_go && mode == RMODE_ARRAY),
        .word_addr(bus_addr[ADDR_W-1:1]),
        .rdata(arr_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q      <= RMODE_ARRAY;
            stat_q     <= '0;
            exit_bad_q <= 1'b0;
        end else begin
            if (rd_go) begin
                src_q <= mode;
                if (mode == RMODE_STATUS) stat_q <= {8'h00, status};
            end
            exit_bad_q <= exit_req && !safe;
        end
    end

    assign bus_rdata = (src_q == RMODE_STATUS) ? stat_q : arr_q;
    assign exit_bad  = exit_bad_q;

    // R11
    exit_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (exit_req && !safe) |=> exit_bad);

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_go |=> $stable(bus_rdata));

endmodule

// File: tb/fcmd_ctrl_bench.sv
module fcmd_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr, bus_rd, flash_reset, exit_req;
    logic [6:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic [2:0]  err_set;
    logic        exit_bad;

    int checks = 0;
    int errors = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    bit          rd_sampled = 0;

    bit          m_status_mode;
    logic [7:0]  m_status;
    bit          m_safe;
    logic [15:0] m_last;

    always #10 clk = ~clk;

    fcmd_ctrl u_fcmd_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .flash_reset(flash_reset), .err_set(err_set),
        .exit_req(exit_req), .exit_bad(exit_bad)
    );

    function automatic logic [15:0] word_at(input int idx);
        int p;
        p = (idx * 40503) % 65536;
        return 16'(p) ^ 16'h1D2C;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: one expected word per sampled read, compared half a clock later
    always @(posedge clk) rd_sampled = bus_rd;
    always @(negedge clk) begin
        if (rd_sampled) begin
            rd_sampled = 0;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R12 actual=%h expected=none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [6:0] a, input logic [15:0] d, input logic [2:0] e);
        bus_wr = 1; bus_addr = a; bus_wdata = d; err_set = e;
        m_status[5:3] = m_status[5:3];
        if (!a[0]) begin
            case (d[7:0])
                8'hFF: begin m_status_mode = 0; m_safe = 1; end
                8'h70: begin m_status_mode = 1; m_safe = 0; end
                8'h50: begin m_status[5:3] = 3'b000; m_safe = 0; end
                default: ;
            endcase
        end
        m_status[5:3] = m_status[5:3] | e;
        @(negedge clk);
        bus_wr = 0; err_set = 0;
    endtask

    task automatic rd(input logic [6:0] a, input string tag);
        logic [15:0] e;
        if (a[0])               e = m_last;
        else if (m_status_mode) begin e = {8'h00, m_status}; m_status_mode = 0; end
        else                    e = word_at(int'(a >> 1));
        m_last = e;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        bus_rd = 0;
        @(negedge clk);
    endtask

    task automatic pulse_err(input logic [2:0] e);
        err_set = e;
        m_status[5:3] = m_status[5:3] | e;
        @(negedge clk);
        err_set = 0;
    endtask

    task automatic freset();
        flash_reset = 1; m_status_mode = 0; m_safe = 1;
        @(negedge clk);
        flash_reset = 0;
    endtask

    task automatic try_exit(input string tag);
        exit_req = 1;
        @(negedge clk);
        exit_req = 0;
        check(tag, {15'd0, exit_bad}, {15'd0, !m_safe});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
        flash_reset = 0; err_set = 0; exit_req = 0;
        m_status_mode = 0; m_status = 8'h80; m_safe = 1; m_last = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1", bus_rdata, 16'h0000);
        check("R1", {15'd0, exit_bad}, 16'h0000);
        rd(7'd0, "R1");
        wr(7'd0, 16'h0070, 3'b000);
        rd(7'd4, "R1");
        rd(7'd4, "R4");
        // R2 / R3 persistent array reads
        wr(7'd2, 16'h00FF, 3'b000);
        rd(7'd0, "R2");
        rd(7'd2, "R2");
        rd(7'd10, "R3");
        rd(7'd126, "R3");
        rd(7'd64, "R3");
        // R7 sticky errors, R5 upper byte ignored
        pulse_err(3'b001);
        pulse_err(3'b100);
        repeat (2) @(negedge clk);
        wr(7'd0, 16'hAB70, 3'b000);
        rd(7'd8, "R5");
        rd(7'd8, "R4");
        // R9 odd accesses ignored
        wr(7'd0, 16'h0070, 3'b000);
        wr(7'd1, 16'h00FF, 3'b000);
        rd(7'd3, "R9");
        rd(7'd6, "R9");
        // R12 hold with no read
        repeat (4) @(negedge clk);
        check("R12", bus_rdata, m_last);
        // R6 clear with simultaneous error
        wr(7'd0, 16'h0050, 3'b010);
        wr(7'd0, 16'h0070, 3'b000);
        rd(7'd0, "R6");
        wr(7'd0, 16'h0050, 3'b000);
        wr(7'd0, 16'h0070, 3'b000);
        rd(7'd0, "R6");
        // R10 unrecognised code keeps status one-shot
        wr(7'd0, 16'h0070, 3'b000);
        wr(7'd0, 16'h0033, 3'b000);
        rd(7'd12, "R10");
        rd(7'd12, "R10");
        // R11 exit guard
        wr(7'd0, 16'h0070, 3'b000);
        try_exit("R11");
        freset();
        try_exit("R11");
        wr(7'd0, 16'h0050, 3'b000);
        wr(7'd0, 16'h0011, 3'b000);
        try_exit("R11");
        wr(7'd0, 16'h00FF, 3'b000);
        try_exit("R11");
        // R8 flash reset returns to array mode, keeps status
        pulse_err(3'b011);
        wr(7'd0, 16'h0070, 3'b000);
        freset();
        rd(7'd20, "R8");
        wr(7'd0, 16'h0070, 3'b000);
        rd(7'd20, "R8");
        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R12 actual=%0d expected=0 pending reads", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule